// File: doc/BRIEF.md
# Mixed-Aspect True Dual-Port Memory

This block is a synchronous memory with two fully independent ports over one shared store of 16,384 data bits and 2,048 parity bits. Each port has its own clock, enable, write enable, address, data and parity buses. At elaboration, each port picks a total width of 1, 2, 4, 9, 18 or 36 bits and an output policy for write cycles. A port can return either the word it is storing or the word it is replacing.

The two ports may use different widths. A narrow port sees the storage as many small locations. A wide port sees it as fewer, larger words. Both views cover the same bits, so data written through one port can be read back through the other in a different shape. The parity lanes sit beside the data lanes and follow the same address relationship. Ports of 1, 2 or 4 bits have no access to parity.

Each port has one read stage. Its output register holds its value while the port is disabled and clears on a synchronous reset of that port. Reset leaves the memory contents unchanged.

Top module: `dpram_mixed`

## Requirements
- R1: A rising clock edge with both enable and write enable high stores the data bus, plus the parity bus for 9, 18 and 36-bit ports, at the addressed location. A later read of that location through the same port returns it.
- R2: A rising clock edge with enable high and write enable low loads the addressed location into the data and parity outputs. The value is visible after that edge.
- R3: A port configured write-first places the value being written on its outputs after a write edge.
- R4: A port configured read-first places the location's contents from before the write on its outputs after a write edge. The new value is stored on the same edge.
- R5: While enable is low, clock edges change neither the outputs nor the memory, whatever write enable, address and data carry.
- R6: A high synchronous reset clears that port's data and parity outputs to zero at the next edge and leaves the memory contents unchanged.
- R7: Total widths 1, 2, 4, 9, 18 and 36 give 8 bits per lane as follows: data widths 1, 2, 4, 8, 16 and 32; parity widths 0, 0, 0, 1, 2 and 4; address widths 14, 13, 12, 11, 10 and 9. Narrow location k of a port with data width d occupies bits (k mod (32/d))·d upward of the 32-bit data word k div (32/d). Its parity slice occupies bits (k mod (32/d))·p upward of the 4-bit parity word at the same index. Lane 0 is at the least significant bits.
- R8: On a 1, 2 or 4-bit port, the parity input is a single ignored bit and the parity output is a single bit that is always zero.
- R9: The two ports run on unrelated clocks. A value written through one port is returned by a later read through the other port at any location that overlaps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, rising edge active |
| rst_a | input | 1 | Port A synchronous output reset, active high |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | addr width of A_WIDTH | Port A location |
| din_a | input | data width of A_WIDTH | Port A write data |
| dinp_a | input | max(parity width, 1) | Port A write parity |
| dout_a | output | data width of A_WIDTH | Port A read data |
| doutp_a | output | max(parity width, 1) | Port A read parity |
| clk_b | input | 1 | Port B clock, rising edge active |
| rst_b | input | 1 | Port B synchronous output reset, active high |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | addr width of B_WIDTH | Port B location |
| din_b | input | data width of B_WIDTH | Port B write data |
| dinp_b | input | max(parity width, 1) | Port B write parity |
| dout_b | output | data width of B_WIDTH | Port B read data |
| doutp_b | output | max(parity width, 1) | Port B read parity |

## Verification
The hardest case to reach is a read-first write on one port that lands inside a word the other port last wrote in a different shape. The old value returned must then combine lanes that came from both ports. Port B first fills the whole store with random wide words. Directed writes and reads then cross the two ports at lane boundaries, followed by a long random mix of reads, writes, idle edges and resets on both ports. Two instances cover both policies on both ports, and both narrow and parity-bearing widths.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic {
    WM_WRITE_FIRST = 1'b0,
    WM_READ_FIRST  = 1'b1
  } wr_mode_e;

  // Storage geometry: one word = 32 data bits + 4 parity bits
  localparam int WORD_DW = 32;
  localparam int WORD_PW = 4;
  localparam int WORD_W  = WORD_DW + WORD_PW;
  localparam int WORDS   = 512;
  localparam int WORD_AW = $clog2(WORDS);

  function automatic bit width_ok(input int total_w);
    return (total_w == 1) || (total_w == 2) || (total_w == 4) ||
           (total_w == 9) || (total_w == 18) || (total_w == 36);
  endfunction

  function automatic int data_w(input int total_w);
    case (total_w)
      9:       return 8;
      18:      return 16;
      36:      return 32;
      2:       return 2;
      4:       return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int par_w(input int total_w);
    return total_w - data_w(total_w);
  endfunction

  function automatic int par_port_w(input int total_w);
    return (par_w(total_w) == 0) ? 1 : par_w(total_w);
  endfunction

  function automatic int addr_w(input int total_w);
    return $clog2((WORD_DW * WORDS) / data_w(total_w));
  endfunction

  // Bit offset of a lane's data slice inside a storage word
  function automatic logic [5:0] data_off(input logic [4:0] lane, input int dw);
    return 6'(int'(lane) * dw);
  endfunction

  // Bit offset of a lane's parity slice inside a storage word
  function automatic logic [5:0] par_off(input logic [4:0] lane, input int pw);
    return 6'(WORD_DW + int'(lane) * pw);
  endfunction

  // Mask of all storage bits one location of a port covers
  function automatic logic [WORD_W-1:0] slice_mask(input logic [5:0] doff,
                                                   input logic [5:0] poff,
                                                   input int dw, input int pw);
    logic [WORD_W-1:0] dlow, plow;
    dlow = WORD_W'((64'd1 << dw) - 64'd1);
    plow = WORD_W'((64'd1 << pw) - 64'd1);
    return (dlow << doff) | (plow << poff);
  endfunction

endpackage

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 36,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_own,
  output logic [WIDTH-1:0] rdata_own,
  input  logic [AW-1:0]    raddr_peer,
  output logic [WIDTH-1:0] rdata_peer
);

  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_own  = mem[raddr_own];
  assign rdata_peer = mem[raddr_peer];

endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int       TOTAL_W = 9,
  parameter wr_mode_e MODE    = WM_WRITE_FIRST,
  localparam int DW  = data_w(TOTAL_W),
  localparam int PW  = par_w(TOTAL_W),
  localparam int PPW = par_port_w(TOTAL_W),
  localparam int AW  = addr_w(TOTAL_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      din,
  input  logic [PPW-1:0]     dinp,
  output logic [DW-1:0]      dout,
  output logic [PPW-1:0]     doutp,
  output logic [WORD_AW-1:0] word_idx,
  input  logic [WORD_W-1:0]  own_word,
  input  logic [WORD_W-1:0]  peer_word,
  output logic               bank_we,
  output logic [WORD_W-1:0]  bank_wdata,
  output logic [DW-1:0]      old_data,
  output logic [PPW-1:0]     old_par,
  output logic               wr_fire
);

  localparam int LB = AW - WORD_AW;  // lane-select address bits

  logic [4:0]        lane;
  logic [5:0]        doff, poff;
  logic [WORD_W-1:0] current;   // logical word = own bank ^ peer bank
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] ins;

  assign word_idx = WORD_AW'(addr >> LB);
  assign lane     = 5'(addr & AW'((1 << LB) - 1));
  assign doff     = data_off(lane, DW);
  assign poff     = par_off(lane, PW);
  assign mask     = slice_mask(doff, poff, DW, PW);
  assign current  = own_word ^ peer_word;

  assign old_data = DW'(current >> doff);
  assign old_par  = (PW == 0) ? '0 : PPW'(current >> poff);

  assign ins = (WORD_W'(din) << doff) |
               ((PW == 0) ? '0 : (WORD_W'(dinp) << poff));

  assign wr_fire    = en & we;
  assign bank_we    = wr_fire;
  assign bank_wdata = (own_word & ~mask) | ((ins ^ peer_word) & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      doutp <= '0;
    end else if (en) begin
      if (we && (MODE == WM_WRITE_FIRST)) begin
        dout  <= din;
        doutp <= (PW == 0) ? '0 : dinp;
      end else begin
        dout  <= old_data;
        doutp <= old_par;
      end
    end
  end

endmodule

// File: rtl/dpram_mixed.sv
module dpram_mixed
  import dpram_pkg::*;
#(
  parameter int       A_WIDTH = 9,
  parameter int       B_WIDTH = 36,
  parameter wr_mode_e A_MODE  = WM_WRITE_FIRST,
  parameter wr_mode_e B_MODE  = WM_READ_FIRST,
  localparam int A_DW  = data_w(A_WIDTH),
  localparam int A_PPW = par_port_w(A_WIDTH),
  localparam int A_AW  = addr_w(A_WIDTH),
  localparam int B_DW  = data_w(B_WIDTH),
  localparam int B_PPW = par_port_w(B_WIDTH),
  localparam int B_AW  = addr_w(B_WIDTH)
) (
  input  logic             clk_a,
  input  logic             rst_a,
  input  logic             en_a,
  input  logic             we_a,
  input  logic [A_AW-1:0]  addr_a,
  input  logic [A_DW-1:0]  din_a,
  input  logic [A_PPW-1:0] dinp_a,
  output logic [A_DW-1:0]  dout_a,
  output logic [A_PPW-1:0] doutp_a,
  input  logic             clk_b,
  input  logic             rst_b,
  input  logic             en_b,
  input  logic             we_b,
  input  logic [B_AW-1:0]  addr_b,
  input  logic [B_DW-1:0]  din_b,
  input  logic [B_PPW-1:0] dinp_b,
  output logic [B_DW-1:0]  dout_b,
  output logic [B_PPW-1:0] doutp_b
);

  if (!width_ok(A_WIDTH)) begin : g_bad_a
    $error("dpram_mixed: A_WIDTH must be 1, 2, 4, 9, 18 or 36");
  end
  if (!width_ok(B_WIDTH)) begin : g_bad_b
    $error("dpram_mixed: B_WIDTH must be 1, 2, 4, 9, 18 or 36");
  end

  logic [WORD_AW-1:0] word_a, word_b;
  logic [WORD_W-1:0]  a_own, a_at_b, b_own, b_at_a;
  logic               bank_we_a, bank_we_b;
  logic [WORD_W-1:0]  bank_wdata_a, bank_wdata_b;
  logic [A_DW-1:0]    a_old_data;
  logic [A_PPW-1:0]   a_old_par;
  logic [B_DW-1:0]    b_old_data;
  logic [B_PPW-1:0]   b_old_par;
  logic               a_wr_fire, b_wr_fire;

  // Bank A is written only from clk_a, bank B only from clk_b.
  dpram_bank #(.DEPTH(WORDS), .WIDTH(WORD_W)) u_bank_a (
    .clk        (clk_a),
    .we         (bank_we_a),
    .waddr      (word_a),
    .wdata      (bank_wdata_a),
    .raddr_own  (word_a),
    .rdata_own  (a_own),
    .raddr_peer (word_b),
    .rdata_peer (a_at_b)
  );

  dpram_bank #(.DEPTH(WORDS), .WIDTH(WORD_W)) u_bank_b (
    .clk        (clk_b),
    .we         (bank_we_b),
    .waddr      (word_b),
    .wdata      (bank_wdata_b),
    .raddr_own  (word_b),
    .rdata_own  (b_own),
    .raddr_peer (word_a),
    .rdata_peer (b_at_a)
  );

  dpram_port #(.TOTAL_W(A_WIDTH), .MODE(A_MODE)) u_port_a (
    .clk        (clk_a),
    .rst        (rst_a),
    .en         (en_a),
    .we         (we_a),
    .addr       (addr_a),
    .din        (din_a),
    .dinp       (dinp_a),
    .dout       (dout_a),
    .doutp      (doutp_a),
    .word_idx   (word_a),
    .own_word   (a_own),
    .peer_word  (b_at_a),
    .bank_we    (bank_we_a),
    .bank_wdata (bank_wdata_a),
    .old_data   (a_old_data),
    .old_par    (a_old_par),
    .wr_fire    (a_wr_fire)
  );

  dpram_port #(.TOTAL_W(B_WIDTH), .MODE(B_MODE)) u_port_b (
    .clk        (clk_b),
    .rst        (rst_b),
    .en         (en_b),
    .we         (we_b),
    .addr       (addr_b),
    .din        (din_b),
    .dinp       (dinp_b),
    .dout       (dout_b),
    .doutp      (doutp_b),
    .word_idx   (word_b),
    .own_word   (b_own),
    .peer_word  (a_at_b),
    .bank_we    (bank_we_b),
    .bank_wdata (bank_wdata_b),
    .old_data   (b_old_data),
    .old_par    (b_old_par),
    .wr_fire    (b_wr_fire)
  );

endmodule

// File: rtl/dpram_mixed_chk.sv
module dpram_mixed_chk
  import dpram_pkg::*;
#(
  parameter int       A_WIDTH = 9,
  parameter int       B_WIDTH = 36,
  parameter wr_mode_e A_MODE  = WM_WRITE_FIRST,
  parameter wr_mode_e B_MODE  = WM_READ_FIRST,
  localparam int A_DW  = data_w(A_WIDTH),
  localparam int A_PW  = par_w(A_WIDTH),
  localparam int A_PPW = par_port_w(A_WIDTH),
  localparam int B_DW  = data_w(B_WIDTH),
  localparam int B_PW  = par_w(B_WIDTH),
  localparam int B_PPW = par_port_w(B_WIDTH)
) (
  input logic             clk_a,
  input logic             rst_a,
  input logic             en_a,
  input logic             we_a,
  input logic [A_DW-1:0]  din_a,
  input logic [A_PPW-1:0] dinp_a,
  input logic [A_DW-1:0]  dout_a,
  input logic [A_PPW-1:0] doutp_a,
  input logic [A_DW-1:0]  a_old_data,
  input logic [A_PPW-1:0] a_old_par,
  input logic             clk_b,
  input logic             rst_b,
  input logic             en_b,
  input logic             we_b,
  input logic [B_DW-1:0]  din_b,
  input logic [B_PPW-1:0] dinp_b,
  input logic [B_DW-1:0]  dout_b,
  input logic [B_PPW-1:0] doutp_b,
  input logic [B_DW-1:0]  b_old_data,
  input logic [B_PPW-1:0] b_old_par
);

  // Port A
  assert_read_a_R2: assert property (@(posedge clk_a) disable iff (rst_a)
    (en_a && !we_a) |=> (dout_a == $past(a_old_data)) && (doutp_a == $past(a_old_par)));

  assert_write_first_a_R3: assert property (@(posedge clk_a) disable iff (rst_a)
    (A_MODE == WM_WRITE_FIRST && en_a && we_a) |=>
      (dout_a == $past(din_a)) && (doutp_a == ((A_PW == 0) ? A_PPW'(0) : $past(dinp_a))));

  assert_read_first_a_R4: assert property (@(posedge clk_a) disable iff (rst_a)
    (A_MODE == WM_READ_FIRST && en_a && we_a) |=>
      (dout_a == $past(a_old_data)) && (doutp_a == $past(a_old_par)));

  assert_hold_a_R5: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> $stable(dout_a) && $stable(doutp_a));

  // Port B
  assert_read_b_R2: assert property (@(posedge clk_b) disable iff (rst_b)
    (en_b && !we_b) |=> (dout_b == $past(b_old_data)) && (doutp_b == $past(b_old_par)));

  assert_write_first_b_R3: assert property (@(posedge clk_b) disable iff (rst_b)
    (B_MODE == WM_WRITE_FIRST && en_b && we_b) |=>
      (dout_b == $past(din_b)) && (doutp_b == ((B_PW == 0) ? B_PPW'(0) : $past(dinp_b))));

  assert_read_first_b_R4: assert property (@(posedge clk_b) disable iff (rst_b)
    (B_MODE == WM_READ_FIRST && en_b && we_b) |=>
      (dout_b == $past(b_old_data)) && (doutp_b == $past(b_old_par)));

  assert_hold_b_R5: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> $stable(dout_b) && $stable(doutp_b));

endmodule

bind dpram_mixed dpram_mixed_chk #(
  .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .A_MODE(A_MODE), .B_MODE(B_MODE)
) u_chk (
  .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .we_a(we_a),
  .din_a(din_a), .dinp_a(dinp_a), .dout_a(dout_a), .doutp_a(doutp_a),
  .a_old_data(a_old_data), .a_old_par(a_old_par),
  .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .we_b(we_b),
  .din_b(din_b), .dinp_b(dinp_b), .dout_b(dout_b), .doutp_b(doutp_b),
  .b_old_data(b_old_data), .b_old_par(b_old_par)
);

// File: tb/tb_dpram_mixed.sv
module tb_dpram_mixed;
  import dpram_pkg::*;

  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = CLK_PERIOD + 4;

  logic clk_a = 1'b0, clk_b = 1'b0;
  always #(CLK_PERIOD / 2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD / 2) clk_b = ~clk_b;

  logic        rst_a, rst_b, en_a, en_b, we_a, we_b;
  logic [13:0] addr_a, addr_b;
  logic [35:0] val_a, val_b;   // {parity[3:0], data[31:0]}

  // Instance 1: A = 4 bits write-first, B = 36 bits read-first
  logic [3:0]  d1_dout_a;  logic [0:0] d1_doutp_a;
  logic [31:0] d1_dout_b;  logic [3:0] d1_doutp_b;
  // Instance 2: A = 9 bits read-first, B = 18 bits write-first
  logic [7:0]  d2_dout_a;  logic [0:0] d2_doutp_a;
  logic [15:0] d2_dout_b;  logic [1:0] d2_doutp_b;

  dpram_mixed #(.A_WIDTH(4), .B_WIDTH(36), .A_MODE(WM_WRITE_FIRST), .B_MODE(WM_READ_FIRST)) dut (
    .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .addr_a(addr_a[11:0]),
    .din_a(val_a[3:0]), .dinp_a(val_a[32:32]), .dout_a(d1_dout_a), .doutp_a(d1_doutp_a),
    .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .addr_b(addr_b[8:0]),
    .din_b(val_b[31:0]), .dinp_b(val_b[35:32]), .dout_b(d1_dout_b), .doutp_b(d1_doutp_b)
  );

  dpram_mixed #(.A_WIDTH(9), .B_WIDTH(18), .A_MODE(WM_READ_FIRST), .B_MODE(WM_WRITE_FIRST)) dut2 (
    .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .addr_a(addr_a[10:0]),
    .din_a(val_a[7:0]), .dinp_a(val_a[32:32]), .dout_a(d2_dout_a), .doutp_a(d2_doutp_a),
    .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .addr_b(addr_b[9:0]),
    .din_b(val_b[15:0]), .dinp_b(val_b[33:32]), .dout_b(d2_dout_b), .doutp_b(d2_doutp_b)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [35:0] model [2][512];
  logic [35:0] last  [2][2];

  // ---- reference arithmetic, restated from the requirements ----
  function automatic int bdw(int w); return (w >= 9) ? (w / 9) * 8 : w; endfunction
  function automatic int bpw(int w); return (w >= 9) ? w / 9 : 0; endfunction
  function automatic int width_of(int inst, bit pb);
    return (inst == 0) ? (pb ? 36 : 4) : (pb ? 18 : 9);
  endfunction
  function automatic bit read_first(int inst, bit pb);
    return (inst == 0) ? pb : !pb;
  endfunction

  function automatic logic [35:0] view(int w, logic [35:0] v);
    logic [35:0] r = '0;
    for (int b = 0; b < bdw(w); b++) r[b] = v[b];
    for (int b = 0; b < bpw(w); b++) r[32+b] = v[32+b];
    return r;
  endfunction

  function automatic logic [35:0] mread(int inst, int w, int addr);
    int dwv = bdw(w), pwv = bpw(w), per = 32 / bdw(w);
    int a = addr % (16384 / bdw(w));
    logic [35:0] x = model[inst][a / per];
    logic [35:0] r = '0;
    for (int b = 0; b < dwv; b++) r[b] = x[(a % per) * dwv + b];
    for (int b = 0; b < pwv; b++) r[32+b] = x[32 + (a % per) * pwv + b];
    return r;
  endfunction

  task automatic mwrite(int inst, int w, int addr, logic [35:0] v);
    int dwv = bdw(w), pwv = bpw(w), per = 32 / bdw(w);
    int a = addr % (16384 / bdw(w));
    for (int b = 0; b < dwv; b++) model[inst][a / per][(a % per) * dwv + b] = v[b];
    for (int b = 0; b < pwv; b++) model[inst][a / per][32 + (a % per) * pwv + b] = v[32+b];
  endtask

  function automatic logic [35:0] got(int inst, bit pb);
    if (inst == 0) return pb ? {d1_doutp_b, d1_dout_b} : {3'b0, d1_doutp_a, 28'b0, d1_dout_a};
    return pb ? {2'b0, d2_doutp_b, 16'b0, d2_dout_b} : {3'b0, d2_doutp_a, 24'b0, d2_dout_a};
  endfunction

  task automatic check(string tag, string what, logic [35:0] act, logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wait_port(bit pb);
    if (pb) @(negedge clk_b); else @(negedge clk_a);
  endtask

  // One enabled or idle edge on one port, checked on both instances
  task automatic op(bit pb, bit e, bit w, int addr, logic [35:0] v, string tag_in);
    logic [35:0] exp [2];
    string tag;
    wait_port(pb);
    if (pb) begin en_b = e; we_b = w; addr_b = 14'(addr); val_b = v; end
    else    begin en_a = e; we_a = w; addr_a = 14'(addr); val_a = v; end
    for (int i = 0; i < 2; i++) begin
      int wd = width_of(i, pb);
      if (!e) exp[i] = last[i][pb];
      else begin
        logic [35:0] old = mread(i, wd, addr);
        if (w) begin
          mwrite(i, wd, addr, v);
          exp[i] = read_first(i, pb) ? old : view(wd, v);
        end else exp[i] = old;
      end
      last[i][pb] = exp[i];
    end
    wait_port(pb);
    for (int i = 0; i < 2; i++) begin
      if (tag_in != "") tag = tag_in;
      else if (!e) tag = "R5";
      else if (!w) tag = "R2";
      else tag = read_first(i, pb) ? "R4" : "R3";
      check(tag, $sformatf("inst%0d port%s addr %0d", i, pb ? "B" : "A", addr), got(i, pb), exp[i]);
    end
    if (pb) en_b = 1'b0; else en_a = 1'b0;
  endtask

  task automatic rst_port(bit pb);
    wait_port(pb);
    if (pb) begin rst_b = 1'b1; en_b = 1'b0; end else begin rst_a = 1'b1; en_a = 1'b0; end
    wait_port(pb);
    for (int i = 0; i < 2; i++) begin
      check("R6", $sformatf("inst%0d reset port%s", i, pb ? "B" : "A"), got(i, pb), '0);
      last[i][pb] = '0;
    end
    if (pb) rst_b = 1'b0; else rst_a = 1'b0;
  endtask

  function automatic logic [35:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog all: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7071));
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < 512; k++) model[i][k] = '0;
      last[i][0] = '0; last[i][1] = '0;
    end
    rst_a = 1'b1; rst_b = 1'b1; en_a = 1'b0; en_b = 1'b0; we_a = 1'b0; we_b = 1'b0;
    addr_a = '0; addr_b = '0; val_a = '0; val_b = '0;
    repeat (3) @(negedge clk_b);
    for (int i = 0; i < 2; i++) begin
      check("R6", "reset state port A", got(i, 1'b0), '0);
      check("R6", "reset state port B", got(i, 1'b1), '0);
    end
    rst_a = 1'b0; rst_b = 1'b0;

    // Fill the store through the wide port
    for (int a = 0; a < 1024; a++) op(1'b1, 1'b1, 1'b1, a, rnd36(), "R1");

    // Same-port write then read
    op(1'b0, 1'b1, 1'b1, 100, 36'h0_0000_00A5, "R1");
    op(1'b0, 1'b1, 1'b0, 100, '0, "R1");
    op(1'b1, 1'b1, 1'b1, 40, 36'h9_1234_5678, "R1");
    op(1'b1, 1'b1, 1'b0, 40, '0, "R1");

    // Narrow write seen through the wide port (lane mapping, other clock)
    op(1'b0, 1'b1, 1'b1, 59, 36'h1_0000_00C3, "R7");
    op(1'b1, 1'b1, 1'b0, 7, '0, "R9");
    op(1'b1, 1'b1, 1'b0, 28, '0, "R7");
    op(1'b1, 1'b1, 1'b0, 29, '0, "R7");

    // Wide write read back lane by lane through the narrow port
    op(1'b1, 1'b1, 1'b1, 3, 36'hA_F0E1_D2C3, "R9");
    for (int l = 0; l < 8; l++) op(1'b0, 1'b1, 1'b0, 24 + l, '0, "R7");

    // Write policies on both ports
    op(1'b0, 1'b1, 1'b1, 77, rnd36(), "");
    op(1'b1, 1'b1, 1'b1, 77, rnd36(), "");

    // Narrow port parity
    op(1'b0, 1'b1, 1'b1, 200, 36'hF_FFFF_FFFF, "R8");
    op(1'b0, 1'b1, 1'b0, 200, '0, "R8");

    // Disabled edges with write enable high
    op(1'b0, 1'b1, 1'b0, 300, '0, "R2");
    op(1'b0, 1'b0, 1'b1, 300, 36'h5_5555_5555, "R5");
    op(1'b0, 1'b1, 1'b0, 300, '0, "R5");
    op(1'b1, 1'b0, 1'b1, 30, 36'hA_AAAA_AAAA, "R5");
    op(1'b1, 1'b1, 1'b0, 30, '0, "R5");

    // Reset clears outputs, keeps memory
    op(1'b0, 1'b1, 1'b1, 400, 36'h1_0000_00FF, "R1");
    rst_port(1'b0);
    op(1'b0, 1'b1, 1'b0, 400, '0, "R6");
    op(1'b1, 1'b1, 1'b1, 50, 36'hF_FFFF_FFFF, "R1");
    rst_port(1'b1);
    op(1'b1, 1'b1, 1'b0, 50, '0, "R6");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      bit pb = 1'($urandom);
      if (($urandom % 50) == 0) rst_port(pb);
      else op(pb, ($urandom % 100) < 85, 1'($urandom), int'($urandom % 16384), rnd36(), "");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule